// File: doc/BRIEF.md
# Debug Trigger Chain Resolver

This block decides, for each instruction, which hardware debug triggers fire. Comparators elsewhere in the chip report a per-trigger hit flag. The resolver combines those flags with a locally held copy of each trigger's configuration. It then produces one registered fire flag per trigger, a flag for triggers that trap before the instruction completes, a flag for triggers that trap on the following instruction, and a summary hit. The same configuration copy is also driven out, so the comparators can use each trigger's match type, select bit, action bit and 64-bit compare value.

There are ten triggers, arranged as five fixed pairs. Pair i holds triggers 2i and 2i+1. The pairs watch, in order, fetch/fetch, store/store, load/load, fetch/store and fetch/load accesses. A pair is chained by the chain bit of its lower trigger. When a pair is chained, it reports a match only if both members hit with the same trap timing. Chaining two store triggers is not supported, so the chain bit of pair 1 is treated as zero.

Configuration is loaded one trigger per cycle through a write port that has a valid, an address and the field values. A `clear_i` pulse suppresses the fire outputs for the following cycle.

Top module: `trig_chain_resolver`

## Requirements
- R1: After reset every configuration output reads zero, every trigger is disabled, and all fire outputs are 0.
- R2: A write with `cfg_wr_valid_i`=1 and `cfg_wr_addr_i` < 10 replaces every field of that trigger. The new values show on the configuration outputs from the next cycle, and the other triggers keep their values. Trigger t occupies bit t of the 1-bit vectors, bits [2t+1:2t] of `cfg_match_type_o` and bits [64t+63:64t] of `cfg_cmp_value_o`.
- R3: A write whose address is 10 to 15 changes no configuration output.
- R4: An unchained trigger fires when it is enabled and its hit flag is set, independently of its partner. A disabled trigger never fires.
- R5: In a chained pair (chain bit of trigger 2i set, pair other than 1), both triggers fire together when both are enabled, both hit and both have the same timing. Otherwise neither fires.
- R6: In a chained pair whose two timing bits differ, neither trigger fires.
- R7: The chain bit of trigger 2 (the store/store pair, triggers 2 and 3) is ignored, so triggers 2 and 3 always behave as unchained.
- R8: `hit_any_o` is the OR of all fire flags. `fire_now_o` is the OR of fired triggers with timing 0, and `fire_next_o` is the OR of fired triggers with timing 1.
- R9: Outputs are registered. The fire outputs in a cycle reflect the hit flags and the configuration of the previous cycle.
- R10: `clear_i`=1 forces all fire outputs to 0 in the following cycle, and has no effect after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_valid_i | input | 1 | Configuration write strobe |
| cfg_wr_addr_i | input | 4 | Trigger index written |
| cfg_wr_enable_i | input | 1 | Trigger enable |
| cfg_wr_match_type_i | input | 2 | Match type |
| cfg_wr_select_i | input | 1 | Select bit |
| cfg_wr_timing_i | input | 1 | 0 = trap at current instruction, 1 = trap at next |
| cfg_wr_action_i | input | 1 | Action bit |
| cfg_wr_chain_i | input | 1 | Chain bit (meaningful on even triggers) |
| cfg_wr_cmp_value_i | input | 64 | Compare value |
| hit_vec_i | input | 10 | Per-trigger hit flags from comparators |
| clear_i | input | 1 | Suppress fire outputs next cycle |
| cfg_enable_o | output | 10 | Stored enables |
| cfg_match_type_o | output | 20 | Stored match types |
| cfg_select_o | output | 10 | Stored select bits |
| cfg_timing_o | output | 10 | Stored timing bits |
| cfg_action_o | output | 10 | Stored action bits |
| cfg_chain_o | output | 10 | Stored chain bits |
| cfg_cmp_value_o | output | 640 | Stored compare values |
| fire_vec_o | output | 10 | Registered per-trigger fire flags |
| fire_now_o | output | 1 | Some fired trigger has timing 0 |
| fire_next_o | output | 1 | Some fired trigger has timing 1 |
| hit_any_o | output | 1 | Some trigger fired |

## Verification
Some properties are checked on every cycle. The summary flags must agree with the fire vector. A trigger may fire only if its hit flag was set the cycle before. The two members of a chained pair must agree, and a chained pair with mismatched timing must stay silent. A clear must empty the outputs, and an out-of-range write must leave the stored configuration untouched. Other behaviour only the bench scenarios can show: the exact fire pattern for every combination of enables, timings, chain bit and hit vector. That sweep also shows that the store/store pair ignores its chain bit, that writes land in the right field positions, that reset leaves everything disabled, and that a clear lasts exactly one cycle.

// File: rtl/trig_chain_pkg.sv
package trig_chain_pkg;
  localparam int CMP_W = 64;

  typedef struct packed {
    logic             enable;
    logic [1:0]       match_type;
    logic             select;
    logic             timing;
    logic             action;
    logic             chain;
    logic [CMP_W-1:0] cmp_value;
  } trig_cfg_t;
endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
  import trig_chain_pkg::*;
#(
  parameter int NUM_TRIG = 10,
  parameter int ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  trig_cfg_t         wr_data_i,
  output trig_cfg_t         cfg_o [NUM_TRIG]
);
  trig_cfg_t cfg_q [NUM_TRIG];
  trig_cfg_t cfg_d [NUM_TRIG];
  logic [NUM_TRIG-1:0] wr_sel;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_entry
    always_comb begin
      wr_sel[g] = wr_valid_i && (wr_addr_i == ADDR_W'(g));
      cfg_d[g]  = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        cfg_q[g] <= '0;
      end else if (wr_sel[g]) begin
        cfg_q[g] <= cfg_d[g];
      end
    end

    assign cfg_o[g] = cfg_q[g];

    // R3: a write to an address beyond the last trigger leaves this entry alone
    assert_bad_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (wr_valid_i && ({1'b0, wr_addr_i} >= (ADDR_W+1)'(NUM_TRIG))) |=> $stable(cfg_q[g]));
  end
endmodule

// File: rtl/trig_pair_resolver.sv
module trig_pair_resolver #(
  parameter bit CHAIN_OK = 1'b1
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic en_lo_i,
  input  logic en_hi_i,
  input  logic tim_lo_i,
  input  logic tim_hi_i,
  input  logic chain_lo_i,
  input  logic hit_lo_i,
  input  logic hit_hi_i,
  output logic fire_lo_o,
  output logic fire_hi_o
);
  localparam logic ALLOW = CHAIN_OK;

  logic solo_lo, solo_hi, chain_on, same_tim, pair_match;

  always_comb begin
    solo_lo    = en_lo_i && hit_lo_i;
    solo_hi    = en_hi_i && hit_hi_i;
    chain_on   = ALLOW && chain_lo_i;
    same_tim   = (tim_lo_i == tim_hi_i);
    pair_match = solo_lo && solo_hi && same_tim;
    fire_lo_o  = chain_on ? pair_match : solo_lo;
    fire_hi_o  = chain_on ? pair_match : solo_hi;
  end

  // R5: members of a chained pair always agree
  assert_pair_agree_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (chain_on) |-> (fire_lo_o == fire_hi_o));

  // R6: mismatched timing in a chained pair silences both
  assert_timing_mismatch_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (chain_on && (tim_lo_i != tim_hi_i)) |-> (!fire_lo_o && !fire_hi_o));
endmodule

// File: rtl/trig_chain_resolver.sv
module trig_chain_resolver
  import trig_chain_pkg::*;
#(
  parameter int          NUM_PAIRS   = 5,
  parameter logic [4:0]  CHAIN_ALLOW = 5'b11101,
  localparam int         NUM_TRIG    = 2 * NUM_PAIRS,
  localparam int         ADDR_W      = $clog2(NUM_TRIG + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_n_i,
  input  logic                      cfg_wr_valid_i,
  input  logic [ADDR_W-1:0]         cfg_wr_addr_i,
  input  logic                      cfg_wr_enable_i,
  input  logic [1:0]                cfg_wr_match_type_i,
  input  logic                      cfg_wr_select_i,
  input  logic                      cfg_wr_timing_i,
  input  logic                      cfg_wr_action_i,
  input  logic                      cfg_wr_chain_i,
  input  logic [CMP_W-1:0]          cfg_wr_cmp_value_i,
  input  logic [NUM_TRIG-1:0]       hit_vec_i,
  input  logic                      clear_i,
  output logic [NUM_TRIG-1:0]       cfg_enable_o,
  output logic [2*NUM_TRIG-1:0]     cfg_match_type_o,
  output logic [NUM_TRIG-1:0]       cfg_select_o,
  output logic [NUM_TRIG-1:0]       cfg_timing_o,
  output logic [NUM_TRIG-1:0]       cfg_action_o,
  output logic [NUM_TRIG-1:0]       cfg_chain_o,
  output logic [CMP_W*NUM_TRIG-1:0] cfg_cmp_value_o,
  output logic [NUM_TRIG-1:0]       fire_vec_o,
  output logic                      fire_now_o,
  output logic                      fire_next_o,
  output logic                      hit_any_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  trig_cfg_t wr_data;
  trig_cfg_t cfg [NUM_TRIG];

  always_comb begin
    wr_data.enable     = cfg_wr_enable_i;
    wr_data.match_type = cfg_wr_match_type_i;
    wr_data.select     = cfg_wr_select_i;
    wr_data.timing     = cfg_wr_timing_i;
    wr_data.action     = cfg_wr_action_i;
    wr_data.chain      = cfg_wr_chain_i;
    wr_data.cmp_value  = cfg_wr_cmp_value_i;
  end

  trig_cfg_bank #(.NUM_TRIG(NUM_TRIG), .ADDR_W(ADDR_W)) u_bank (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .wr_valid_i (cfg_wr_valid_i),
    .wr_addr_i  (cfg_wr_addr_i),
    .wr_data_i  (wr_data),
    .cfg_o      (cfg)
  );

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_flat
    assign cfg_enable_o[t]                   = cfg[t].enable;
    assign cfg_match_type_o[2*t +: 2]        = cfg[t].match_type;
    assign cfg_select_o[t]                   = cfg[t].select;
    assign cfg_timing_o[t]                   = cfg[t].timing;
    assign cfg_action_o[t]                   = cfg[t].action;
    assign cfg_chain_o[t]                    = cfg[t].chain;
    assign cfg_cmp_value_o[CMP_W*t +: CMP_W] = cfg[t].cmp_value;
  end

  logic [NUM_TRIG-1:0] fire_d;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    trig_pair_resolver #(.CHAIN_OK(CHAIN_ALLOW[p])) u_pair (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n),
      .en_lo_i    (cfg[2*p].enable),
      .en_hi_i    (cfg[2*p+1].enable),
      .tim_lo_i   (cfg[2*p].timing),
      .tim_hi_i   (cfg[2*p+1].timing),
      .chain_lo_i (cfg[2*p].chain),
      .hit_lo_i   (hit_vec_i[2*p]),
      .hit_hi_i   (hit_vec_i[2*p+1]),
      .fire_lo_o  (fire_d[2*p]),
      .fire_hi_o  (fire_d[2*p+1])
    );
  end

  // next-state of the output stage
  logic [NUM_TRIG-1:0] fire_n;
  logic now_n, next_n, any_n;

  always_comb begin
    if (clear_i) begin
      fire_n = '0;
      now_n  = 1'b0;
      next_n = 1'b0;
      any_n  = 1'b0;
    end else begin
      fire_n = fire_d;
      now_n  = |(fire_d & ~cfg_timing_o);
      next_n = |(fire_d & cfg_timing_o);
      any_n  = |fire_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      fire_vec_o  <= '0;
      fire_now_o  <= 1'b0;
      fire_next_o <= 1'b0;
      hit_any_o   <= 1'b0;
    end else begin
      fire_vec_o  <= fire_n;
      fire_now_o  <= now_n;
      fire_next_o <= next_n;
      hit_any_o   <= any_n;
    end
  end

  // R8: summary flag tracks the fire vector
  assert_summary_any_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_any_o == (|fire_vec_o));

  // R8: every fired trigger traps either now or next
  assert_summary_split_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fire_now_o || fire_next_o) == hit_any_o);

  // R9: no trigger fires without a hit one cycle earlier
  assert_hit_needed_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fire_vec_o & ~$past(hit_vec_i)) == '0);

  // R10: clear empties every fire output on the next cycle
  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    clear_i |=> (fire_vec_o == '0 && !fire_now_o && !fire_next_o && !hit_any_o));
endmodule

// File: tb/trig_chain_resolver_tb_top.sv
`timescale 1ns/1ps
module trig_chain_resolver_tb_top;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic          wr_valid;
  logic [3:0]    wr_addr;
  logic          wr_en, wr_sel, wr_tim, wr_act, wr_chain;
  logic [1:0]    wr_mt;
  logic [63:0]   wr_cmp;
  logic [N-1:0]  hit;
  logic          clear;
  logic [N-1:0]  c_en, c_sel, c_tim, c_act, c_chain, fire;
  logic [2*N-1:0]  c_mt;
  logic [64*N-1:0] c_cmp;
  logic          f_now, f_next, f_any;

  trig_chain_resolver dut_i (
    .clk_i(clk), .rst_n_i(rst_n),
    .cfg_wr_valid_i(wr_valid), .cfg_wr_addr_i(wr_addr),
    .cfg_wr_enable_i(wr_en), .cfg_wr_match_type_i(wr_mt),
    .cfg_wr_select_i(wr_sel), .cfg_wr_timing_i(wr_tim),
    .cfg_wr_action_i(wr_act), .cfg_wr_chain_i(wr_chain),
    .cfg_wr_cmp_value_i(wr_cmp),
    .hit_vec_i(hit), .clear_i(clear),
    .cfg_enable_o(c_en), .cfg_match_type_o(c_mt), .cfg_select_o(c_sel),
    .cfg_timing_o(c_tim), .cfg_action_o(c_act), .cfg_chain_o(c_chain),
    .cfg_cmp_value_o(c_cmp),
    .fire_vec_o(fire), .fire_now_o(f_now), .fire_next_o(f_next), .hit_any_o(f_any)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] cmp_of(input int a, input int combo);
    return {32'hC0DE_0000 | 32'(a), 32'(combo)};
  endfunction

  // expected fire vector: c[0]=en even, c[1]=en odd, c[2]=tim even, c[3]=tim odd, c[4]=chain
  function automatic logic [N-1:0] model(input logic [4:0] c, input logic [N-1:0] h);
    logic [N-1:0] r;
    for (int p = 0; p < N/2; p++) begin
      logic lo, hi, ch;
      lo = c[0] & h[2*p];
      hi = c[1] & h[2*p+1];
      ch = c[4] && (p != 1);
      if (ch) begin
        r[2*p]   = lo & hi & (c[2] == c[3]);
        r[2*p+1] = r[2*p];
      end else begin
        r[2*p]   = lo;
        r[2*p+1] = hi;
      end
    end
    return r;
  endfunction

  task automatic write_cfg(input int a, input logic en, input logic tim,
                           input logic ch, input logic [63:0] cmpv);
    wr_valid = 1'b1;
    wr_addr  = 4'(a);
    wr_en    = en;
    wr_mt    = 2'(a);
    wr_sel   = a[0];
    wr_tim   = tim;
    wr_act   = ~a[0];
    wr_chain = ch;
    wr_cmp   = cmpv;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_combo(input logic [4:0] c, input int id);
    for (int a = 0; a < N; a++)
      write_cfg(a, a[0] ? c[1] : c[0], a[0] ? c[3] : c[2], c[4], cmp_of(a, id));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] exp_f, t_vec;
    logic [64*N-1:0] snap_cmp;
    logic [N-1:0] snap_en, snap_tim;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_en = 0; wr_mt = 0;
    wr_sel = 0; wr_tim = 0; wr_act = 0; wr_chain = 0; wr_cmp = '0;
    hit = '0; clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 cfg_enable", 64'(c_en), 64'd0);
    chk("R1 cfg_cmp_value", 64'(|c_cmp), 64'd0);
    chk("R1 cfg_misc", 64'({c_mt, c_sel, c_tim, c_act, c_chain}), 64'd0);
    chk("R1 fire", 64'({fire, f_now, f_next, f_any}), 64'd0);
    // R4: disabled triggers ignore hits
    hit = '1;
    @(negedge clk);
    chk("R4 disabled", 64'({fire, f_any}), 64'd0);
    hit = '0;

    // exhaustive sweep over shared pair configuration and all hit vectors
    for (int cb = 0; cb < 32; cb++) begin
      logic [4:0] c;
      c = 5'(cb);
      load_combo(c, cb);
      // R2: written fields visible at their positions
      for (int a = 0; a < N; a++) begin
        chk("R2 enable", 64'(c_en[a]), 64'(a[0] ? c[1] : c[0]));
        chk("R2 timing", 64'(c_tim[a]), 64'(a[0] ? c[3] : c[2]));
        chk("R2 fields", 64'({c_mt[2*a +: 2], c_sel[a], c_act[a], c_chain[a]}),
            64'({2'(a), a[0], ~a[0], c[4]}));
        chk("R2 cmp_value", c_cmp[64*a +: 64], cmp_of(a, cb));
      end
      for (int t = 0; t < N; t++) t_vec[t] = t[0] ? c[3] : c[2];
      for (int hv = 0; hv < (1 << N); hv++) begin
        hit = N'(hv);
        exp_f = model(c, N'(hv));
        @(negedge clk);
        // R4 unchained, R5 chained, R6 timing mismatch
        chk(c[4] ? (c[2] != c[3] ? "R6 chained mismatch" : "R5 chained") : "R4 unchained",
            64'({fire[9:4], fire[1:0]}), 64'({exp_f[9:4], exp_f[1:0]}));
        chk("R7 store pair", 64'(fire[3:2]), 64'(exp_f[3:2]));
        chk("R8 summary", 64'({f_now, f_next, f_any}),
            64'({|(exp_f & ~t_vec), |(exp_f & t_vec), |exp_f}));
      end
      hit = '0;
      @(negedge clk);
    end

    // R9: one cycle latency, single-cycle hit pulse
    load_combo(5'b00011, 99);
    hit = 10'h021;
    @(negedge clk);
    chk("R9 pulse seen", 64'(fire), 64'h021);
    hit = '0;
    @(negedge clk);
    chk("R9 pulse gone", 64'({fire, f_any}), 64'd0);
    // R9: configuration change takes effect with the same latency
    write_cfg(5, 1'b0, 1'b0, 1'b0, 64'd5);
    hit = 10'h021;
    @(negedge clk);
    chk("R9 new cfg", 64'(fire), 64'h001);
    hit = '0;

    // R10: clear suppresses exactly one cycle
    hit = '1;
    clear = 1'b1;
    @(negedge clk);
    chk("R10 cleared", 64'({fire, f_now, f_next, f_any}), 64'd0);
    clear = 1'b0;
    @(negedge clk);
    chk("R10 released", 64'(fire), 64'h3DF);
    hit = '0;
    @(negedge clk);

    // R3: out-of-range writes ignored
    snap_cmp = c_cmp; snap_en = c_en; snap_tim = c_tim;
    for (int a = N; a < 16; a++) begin
      write_cfg(a, 1'b1, 1'b1, 1'b1, '1);
      chk("R3 cmp untouched", 64'(c_cmp != snap_cmp), 64'd0);
      chk("R3 en/tim untouched", 64'({c_en, c_tim}), 64'({snap_en, snap_tim}));
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule